// File: doc/BRIEF.md
# Swapped Program-Counter / Address-Register Sequencer

This block generates memory addresses for a very small processor on a device with few registers to spare. It holds two address-wide registers: a program counter and an address register. They are wired in a ring. The program counter feeds a step adder that adds 0 or 1, the adder result loads the address register, and the address register loads back into the program counter. The memory address bus is driven by the address register alone, so there is no multiplexer between the two pointers and the bus.

Each instruction passes through four named phases, and the two registers are exchanged exactly twice:

- **PH_FETCH**: the address register holds the instruction address, and the opcode is fetched.
- **PH_XCH_A**: the first exchange. The parked data pointer is brought into the address register, optionally stepped by one, and the instruction address is parked in the program counter.
- **PH_ACCESS**: the operand is read or written through the data pointer.
- **PH_XCH_B**: the second exchange. The instruction address returns to the address register plus one, and the data pointer is parked again.

Two instruction controls bypass the adder:

- A load-pointer instruction replaces the data pointer with a supplied value during PH_XCH_A.
- A jump replaces the next instruction address during PH_XCH_B.

The sequencer moves only when `adv` is high, so an external controller can stall in any phase.

Top module: `addr_swap_unit`

## Requirements
- R1: While reset is low, and in the cycle after it, `mem_addr` is 0, `phase` is PH_FETCH (code 0), and both strobes are low when `adv` is low.
- R2: On each clock edge with `adv` high, `phase` moves PH_FETCH(0) -> PH_XCH_A(1) -> PH_ACCESS(2) -> PH_XCH_B(3) -> PH_FETCH(0). With `adv` low, `phase` and `mem_addr` hold. PH_FETCH and PH_ACCESS never change `mem_addr`.
- R3: `fetch_stb` is high exactly in PH_FETCH with `adv` high. `oper_stb` is high exactly in PH_ACCESS with `adv` high. The two strobes are never high together.
- R4: An advancing PH_XCH_A without `load_ptr` makes `mem_addr` equal the parked data pointer plus `inc_sel` (0 or 1), and parks the current instruction address.
- R5: An advancing PH_XCH_B without `jump` makes `mem_addr` equal the instruction address of the current instruction plus one, and parks the current data pointer.
- R6: An advancing PH_XCH_A with `load_ptr` high makes `mem_addr` equal `load_val`. `inc_sel` has no effect in that cycle.
- R7: An advancing PH_XCH_B with `jump` high makes the next instruction address equal `load_val`.
- R8: `load_ptr` and `inc_sel` have no effect outside an advancing PH_XCH_A. `jump` has no effect outside an advancing PH_XCH_B.
- R9: Address arithmetic wraps modulo 2^AW: stepping the all-ones address gives 0, both for the instruction address and for the data pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance the sequencer by one phase this cycle |
| inc_sel | input | 1 | Step the data pointer by one as it enters the address register in PH_XCH_A |
| load_ptr | input | 1 | Replace the data pointer with `load_val` in PH_XCH_A |
| jump | input | 1 | Replace the next instruction address with `load_val` in PH_XCH_B |
| load_val | input | AW | Operand address or jump target |
| mem_addr | output | AW | Memory address, always the address register |
| phase | output | 2 | Current phase: 0 fetch, 1 first exchange, 2 access, 3 second exchange |
| fetch_stb | output | 1 | Opcode fetch strobe |
| oper_stb | output | 1 | Operand access strobe |

## Verification
The main function is driven with random `adv` stalls mixed with random `inc_sel`, `load_ptr`, `jump` and `load_val` in every phase. This separates a correctly timed exchange from one that fires in the wrong phase or while stalled. Control bits raised in phases where they must be ignored show whether the adder bypass is correctly gated, because any leak shows up as a wrong address in the following fetch or access. Directed runs jump to the all-ones address and load an all-ones pointer with a step, which tells wrapping arithmetic apart from a carry that spills or saturates.

// File: rtl/addr_swap_pkg.sv
package addr_swap_pkg;
    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_XCH_A  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_XCH_B  = 2'd3
    } phase_t;
endpackage

// File: rtl/addr_seq_fsm.sv
module addr_seq_fsm
    import addr_swap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    output phase_t phase,
    output logic   fetch_stb,
    output logic   oper_stb,
    output logic   xch,
    output logic   second_xch
);
    phase_t nxt;

    always_comb begin
        unique case (phase)
            PH_FETCH:  nxt = PH_XCH_A;
            PH_XCH_A:  nxt = PH_ACCESS;
            PH_ACCESS: nxt = PH_XCH_B;
            PH_XCH_B:  nxt = PH_FETCH;
            default:   nxt = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase <= PH_FETCH;
        else if (adv) phase <= nxt;
    end

    always_comb begin
        fetch_stb  = 1'b0;
        oper_stb   = 1'b0;
        xch        = 1'b0;
        second_xch = 1'b0;
        unique case (phase)
            PH_FETCH:  fetch_stb = adv;
            PH_XCH_A:  xch       = adv;
            PH_ACCESS: oper_stb  = adv;
            PH_XCH_B: begin
                xch        = adv;
                second_xch = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/step_adder.sv
module step_adder #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base,
    input  logic          step,
    output logic [AW-1:0] sum
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb sum = step ? base + ONE : base;
endmodule

// File: rtl/ptr_ring.sv
module ptr_ring #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xch,
    input  logic [AW-1:0] ar_nxt,
    output logic [AW-1:0] ar_q,
    output logic [AW-1:0] pc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q <= '0;
            pc_q <= '0;
        end else if (xch) begin
            ar_q <= ar_nxt;
            pc_q <= ar_q;
        end
    end
endmodule

// File: rtl/addr_swap_unit.sv
module addr_swap_unit
    import addr_swap_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          inc_sel,
    input  logic          load_ptr,
    input  logic          jump,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    phase,
    output logic          fetch_stb,
    output logic          oper_stb
);
    phase_t        ph;
    logic          xch;
    logic          second_xch;
    logic          step;
    logic          bypass;
    logic [AW-1:0] sum;
    logic [AW-1:0] ar_nxt;
    logic [AW-1:0] ar_q;
    logic [AW-1:0] pc_q;

    addr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .phase      (ph),
        .fetch_stb  (fetch_stb),
        .oper_stb   (oper_stb),
        .xch        (xch),
        .second_xch (second_xch)
    );

    // The second exchange always advances the program; the first exchange
    // steps the data pointer only on request.
    assign step   = second_xch ? 1'b1 : inc_sel;
    assign bypass = second_xch ? jump : load_ptr;

    step_adder #(.AW(AW)) u_add (
        .base (pc_q),
        .step (step),
        .sum  (sum)
    );

    assign ar_nxt = bypass ? load_val : sum;

    ptr_ring #(.AW(AW)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .xch    (xch),
        .ar_nxt (ar_nxt),
        .ar_q   (ar_q),
        .pc_q   (pc_q)
    );

    assign mem_addr = ar_q;
    assign phase    = ph;
endmodule

// File: rtl/addr_swap_chk.sv
module addr_swap_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv,
    input logic          load_ptr,
    input logic          jump,
    input logic [AW-1:0] load_val,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] pc_q,
    input logic [1:0]    phase,
    input logic          fetch_stb,
    input logic          oper_stb
);
    localparam logic [AW-1:0] ONE = AW'(1);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (phase == 2'd0 && mem_addr == '0));

    p_phase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> phase == 2'($past(phase) + 2'd1));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(phase) && $stable(mem_addr)));

    p_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (phase == 2'd0 || phase == 2'd2)) |=> $stable(mem_addr));

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_stb, oper_stb}));

    p_fetch_then_xch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> phase == 2'd1);

    p_next_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase == 2'd3 && !jump) |=> mem_addr == $past(pc_q) + ONE);

    p_load_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase == 2'd1 && load_ptr) |=> mem_addr == $past(load_val));

    p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase == 2'd3 && jump) |=> mem_addr == $past(load_val));
endmodule

bind addr_swap_unit addr_swap_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .load_ptr  (load_ptr),
    .jump      (jump),
    .load_val  (load_val),
    .mem_addr  (mem_addr),
    .pc_q      (pc_q),
    .phase     (phase),
    .fetch_stb (fetch_stb),
    .oper_stb  (oper_stb)
);

// File: tb/tb_addr_swap_unit.sv
`timescale 1ns/1ps
module tb_addr_swap_unit;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0, inc_sel = 1'b0, load_ptr = 1'b0, jump = 1'b0;
    logic [AW-1:0] load_val = '0;
    logic [AW-1:0] mem_addr;
    logic [1:0]    phase;
    logic          fetch_stb, oper_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench reference model
    logic [1:0]    m_ph = 2'd0;
    logic [AW-1:0] m_fa = '0;
    logic [AW-1:0] m_dp = '0;
    string         tag = "R1";

    always #2 clk = ~clk;

    addr_swap_unit #(.AW(AW)) dut (
        .clk (clk), .rst_n (rst_n), .adv (adv), .inc_sel (inc_sel),
        .load_ptr (load_ptr), .jump (jump), .load_val (load_val),
        .mem_addr (mem_addr), .phase (phase),
        .fetch_stb (fetch_stb), .oper_stb (oper_stb)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [1:0] ph,
                                               input logic [AW-1:0] fa,
                                               input logic [AW-1:0] dp);
        return (ph < 2'd2) ? fa : dp;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic a, input logic i, input logic lp,
                         input logic jp, input logic [AW-1:0] v);
        logic [AW-1:0] nfa, ndp;
        @(negedge clk);
        adv = a; inc_sel = i; load_ptr = lp; jump = jp; load_val = v;
        #0.5;
        check({tag, " addr"}, int'(mem_addr), int'(exp_addr(m_ph, m_fa, m_dp)));
        check("R2 phase", int'(phase), int'(m_ph));
        check("R3 fetch_stb", int'(fetch_stb), int'(a && m_ph == 2'd0));
        check("R3 oper_stb", int'(oper_stb), int'(a && m_ph == 2'd2));
        @(posedge clk);
        nfa = m_fa; ndp = m_dp;
        tag = "R2";
        if (a) begin
            if (m_ph == 2'd1) begin
                ndp = lp ? v : m_dp + AW'(i);
                tag = lp ? "R6" : ((m_dp == '1 && i) ? "R9" : "R4");
            end else if (m_ph == 2'd3) begin
                nfa = jp ? v : m_fa + AW'(1);
                tag = jp ? "R7" : ((m_fa == '1) ? "R9" : "R5");
            end
            if ((m_ph != 2'd1 && (lp || i)) || (m_ph != 2'd3 && jp)) tag = "R8";
            m_ph = m_ph + 2'd1;
        end else if (lp || jp || i) begin
            tag = "R8";
        end
        m_fa = nfa; m_dp = ndp;
    endtask

    initial begin
        #80000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        #9;
        // R1: reset state
        check("R1 addr", int'(mem_addr), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 strobes", int'({fetch_stb, oper_stb}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        // Directed: stall in fetch (R2 hold), ignored controls (R8)
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h55);
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h66);   // fetch: all ignored, R8
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h77);   // XCH_A +1, jump ignored
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);   // access
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);   // R7: jump to FF
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);   // fetch at FF
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'hFF);   // R6: pointer = FF
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);   // R9: FF+1 -> 00 fetch
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);   // R9: pointer FF+1 -> 00
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        // Constrained random
        for (int k = 0; k < 4000; k++) begin
            cycle(($urandom % 4) != 0, $urandom % 2,
                  ($urandom % 4) == 0, ($urandom % 5) == 0, AW'($urandom));
        end
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule